// File: doc/BRIEF.md
# Card Host Controller Register Bank

This block is the software-visible face of a memory-card host controller. It decodes 32-bit word accesses from a single-cycle read/write strobe and holds the configuration words for power, clock, command argument, command word, data timer, data length and data control. It also keeps the response words captured from the command controller, a byte countdown for the current transfer, and a status word. Eleven sticky event bits are set by the engines and cleared by software through a write-one-to-clear location. Eleven further live flags are sampled from the FIFO side every cycle. Two mask words each gate the status word onto one of two registered interrupt lines. An identification window at the top of the map returns a fixed byte signature.

The command controller, the data engine and the data FIFO sit behind simple ports. Software sees the FIFO through a 16-word window whose addresses all alias one FIFO. Each successful FIFO read raises a hold towards the data engine. The hold stays up until software next reads either the status word or the FIFO word-count, so no fresh card data can arrive while a driver is still reading a burst.

Top module: `card_host_regs`

## Requirements
- R1: After reset every register, both masks, the hold flag, both interrupt lines, the error pulse and both start pulses are zero.
- R2: Power (0x00), clock (0x04) and data control (0x2C) keep bits 7:0 of a write, data length (0x28) keeps bits 15:0, and argument (0x08) and data timer (0x24) keep all 32 bits. Each reads back from its own offset.
- R3: A write to the command word (0x0C) with bit 10 set raises `cmd_start_o` for exactly the cycle after the write. The stored command word reads back with bit 10 cleared. A write with bit 10 clear raises no start.
- R4: A data control write with bit 0 set copies data length into the byte count (0x30) and raises `data_start_o` for the next cycle. Each `byte_done_i` cycle lowers a nonzero count by one, and a zero count stays zero. The FIFO word count (0x48) reads as (count + 3) / 4.
- R5: A `resp_valid_i` cycle captures the 6-bit command index (readable at 0x10) and four response words (0x14, 0x18, 0x1C, 0x20, word k taken from bits 32k+31:32k).
- R6: The status word (0x34) holds sticky event bits 10:0, set by `evt_set_i`, and bits 21:11, which show `live_flags_i` one cycle late. A write to 0x38 clears each of bits 10:0 written as 1 and leaves bits 21:11 alone. A set and a clear of the same bit in one cycle leave the bit set.
- R7: Interrupt line n goes high one cycle after the status word ANDed with mask n (0x3C for line 0, 0x40 for line 1) becomes nonzero, and low one cycle after it becomes zero.
- R8: Reads at 0xFE0 to 0xFFC return one byte per word: 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: A read at any word address 0x80 to 0xBC with the FIFO non-empty pulses `fifo_pop_o` in that cycle and returns `fifo_rdata_i`. With the FIFO empty, such a read returns 0, does not pop and does not set the hold.
- R10: A FIFO pop sets `eng_hold_o` from the next cycle. A read of the status word or of the FIFO word count clears it from the next cycle.
- R11: A write to the FIFO window pulses `fifo_push_o` with `fifo_wdata_o` equal to the bus data when the byte count is nonzero. When the count is zero, `fifo_push_o` stays low.
- R12: An access to any other offset, or to an address that is not word-aligned, reads 0 and changes no register. `bus_err_o` is high for the single cycle after such an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| bus_err_o | output | 1 | Unmapped-access pulse, one cycle after the access |
| power_o | output | 8 | Power register |
| clock_o | output | 8 | Clock register |
| cmd_word_o | output | 32 | Stored command word |
| cmd_arg_o | output | 32 | Command argument |
| cmd_start_o | output | 1 | Command issue pulse |
| resp_valid_i | input | 1 | Response capture strobe |
| resp_idx_i | input | 6 | Responding command index |
| resp_words_i | input | 128 | Four response words |
| data_timer_o | output | 32 | Data timeout value |
| data_ctrl_o | output | 8 | Data control register |
| data_count_o | output | 16 | Remaining byte count |
| data_start_o | output | 1 | Transfer start pulse |
| byte_done_i | input | 1 | One byte moved by the data engine |
| evt_set_i | input | 11 | Sticky status event sets |
| live_flags_i | input | 11 | Live FIFO flags for status bits 21:11 |
| fifo_rdata_i | input | 32 | FIFO head word |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_pop_o | output | 1 | FIFO pop strobe |
| fifo_push_o | output | 1 | FIFO push strobe |
| fifo_wdata_o | output | 32 | FIFO push data |
| eng_hold_o | output | 1 | Hold for the data engine |
| irq_o | output | 2 | Masked interrupt lines |

## Verification
Every cycle, the embedded properties check the following. An interrupt line rises only when the masked status was nonzero a cycle earlier. A FIFO pop always raises the hold, and a status or count read always drops it. A written clear bit really drops an event bit that is not being set at the same time. The byte count only rises on a load. An error pulse follows only an access. The read values are shown only by the bench scenarios: the field widths, the cleared go bit in the stored command, the count rounding, the identification sequence, the set-beats-clear case, the ignored FIFO write at zero count and the one-cycle lag of the interrupt lines.

// File: rtl/hc_regs_pkg.sv
package hc_regs_pkg;
    parameter int HC_DW       = 32;
    parameter int HC_AW       = 12;
    parameter int HC_NARROW_W = 8;
    parameter int HC_LEN_W    = 16;
    parameter int HC_STICKY_W = 11;
    parameter int HC_LIVE_W   = 11;
    parameter int HC_NIRQ     = 2;
    parameter int HC_NRESP    = 4;
    parameter int HC_IDX_W    = 6;
    parameter int HC_GO_BIT   = 10;
    localparam int HC_STAT_W  = HC_STICKY_W + HC_LIVE_W;
    localparam int HC_SUB_W   = $clog2(HC_NRESP);

    typedef enum logic [4:0] {
        SEL_NONE, SEL_PWR, SEL_CLK, SEL_ARG, SEL_CMD, SEL_RCMD, SEL_RESP,
        SEL_DTMR, SEL_DLEN, SEL_DCTL, SEL_DCNT, SEL_STAT, SEL_CLR, SEL_MASK,
        SEL_FCNT, SEL_FIFO, SEL_ID
    } hc_sel_e;

    typedef struct packed {
        logic [HC_NARROW_W-1:0]              pwr;
        logic [HC_NARROW_W-1:0]              clk;
        logic [HC_DW-1:0]                    arg;
        logic [HC_DW-1:0]                    cmd;
        logic [HC_IDX_W-1:0]                 rcmd;
        logic [HC_NRESP-1:0][HC_DW-1:0]      resp;
        logic [HC_DW-1:0]                    dtmr;
        logic [HC_LEN_W-1:0]                 dlen;
        logic [HC_NARROW_W-1:0]              dctl;
        logic [HC_LEN_W-1:0]                 dcnt;
        logic [HC_STICKY_W-1:0]              sticky;
        logic [HC_LIVE_W-1:0]                live;
        logic [HC_NIRQ-1:0][HC_STAT_W-1:0]   mask;
        logic                                defer;
        logic                                cmd_go;
        logic                                data_go;
        logic                                err;
    } hc_state_t;
endpackage

// File: rtl/hc_addr_decode.sv
module hc_addr_decode
    import hc_regs_pkg::*;
#(
    parameter int AW = HC_AW
) (
    input  logic [AW-1:0]       addr_i,
    output hc_sel_e             sel_o,
    output logic [HC_SUB_W-1:0] sub_o,
    output logic [2:0]          id_idx_o
);
    logic [AW-1:0] resp_off;

    always_comb begin
        resp_off = addr_i - AW'('h014);
        sel_o    = SEL_NONE;
        sub_o    = '0;
        id_idx_o = addr_i[4:2];
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i >= AW'('hFE0)) begin
                sel_o = SEL_ID;
            end else if (addr_i >= AW'('h080) && addr_i <= AW'('h0BC)) begin
                sel_o = SEL_FIFO;
            end else begin
                case (addr_i)
                    AW'('h000): sel_o = SEL_PWR;
                    AW'('h004): sel_o = SEL_CLK;
                    AW'('h008): sel_o = SEL_ARG;
                    AW'('h00C): sel_o = SEL_CMD;
                    AW'('h010): sel_o = SEL_RCMD;
                    AW'('h014), AW'('h018), AW'('h01C), AW'('h020): begin
                        sel_o = SEL_RESP;
                        sub_o = resp_off[HC_SUB_W+1:2];
                    end
                    AW'('h024): sel_o = SEL_DTMR;
                    AW'('h028): sel_o = SEL_DLEN;
                    AW'('h02C): sel_o = SEL_DCTL;
                    AW'('h030): sel_o = SEL_DCNT;
                    AW'('h034): sel_o = SEL_STAT;
                    AW'('h038): sel_o = SEL_CLR;
                    AW'('h03C): sel_o = SEL_MASK;
                    AW'('h040): begin
                        sel_o = SEL_MASK;
                        sub_o = HC_SUB_W'(1);
                    end
                    AW'('h048): sel_o = SEL_FCNT;
                    default:    sel_o = SEL_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/hc_id_rom.sv
module hc_id_rom (
    input  logic [2:0] idx_i,
    output logic [7:0] byte_o
);
    always_comb begin
        case (idx_i)
            3'd0:    byte_o = 8'h81;
            3'd1:    byte_o = 8'h11;
            3'd2:    byte_o = 8'h04;
            3'd3:    byte_o = 8'h00;
            3'd4:    byte_o = 8'h0D;
            3'd5:    byte_o = 8'hF0;
            3'd6:    byte_o = 8'h05;
            default: byte_o = 8'hB1;
        endcase
    end
endmodule

// File: rtl/hc_irq_gen.sv
module hc_irq_gen #(
    parameter int NIRQ = 2,
    parameter int SW   = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SW-1:0]            status_i,
    input  logic [NIRQ-1:0][SW-1:0]  mask_i,
    output logic [NIRQ-1:0]          irq_o
);
    logic [NIRQ-1:0] irq_d, irq_q;

    for (genvar g = 0; g < NIRQ; g++) begin : g_line
        always_comb irq_d[g] = |(status_i & mask_i[g]);

        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[g] <= 1'b0;
            else        irq_q[g] <= irq_d[g];
        end

        // R7
        irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_q[g]) |-> $past(|(status_i & mask_i[g])));
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/card_host_regs.sv
module card_host_regs
    import hc_regs_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel_i,
    input  logic         bus_wr_i,
    input  logic [11:0]  bus_addr_i,
    input  logic [31:0]  bus_wdata_i,
    output logic [31:0]  bus_rdata_o,
    output logic         bus_err_o,
    output logic [7:0]   power_o,
    output logic [7:0]   clock_o,
    output logic [31:0]  cmd_word_o,
    output logic [31:0]  cmd_arg_o,
    output logic         cmd_start_o,
    input  logic         resp_valid_i,
    input  logic [5:0]   resp_idx_i,
    input  logic [127:0] resp_words_i,
    output logic [31:0]  data_timer_o,
    output logic [7:0]   data_ctrl_o,
    output logic [15:0]  data_count_o,
    output logic         data_start_o,
    input  logic         byte_done_i,
    input  logic [10:0]  evt_set_i,
    input  logic [10:0]  live_flags_i,
    input  logic [31:0]  fifo_rdata_i,
    input  logic         fifo_empty_i,
    output logic         fifo_pop_o,
    output logic         fifo_push_o,
    output logic [31:0]  fifo_wdata_o,
    output logic         eng_hold_o,
    output logic [1:0]   irq_o
);
    hc_state_t q, d;

    hc_sel_e               sel;
    logic [HC_SUB_W-1:0]   sub;
    logic [2:0]            id_idx;
    logic [7:0]            id_byte;
    logic                  rd_acc, wr_acc;
    logic [HC_STICKY_W-1:0] clr_bits;
    logic [HC_STAT_W-1:0]  status;
    logic [HC_LEN_W:0]     fcnt;

    hc_addr_decode #(.AW(HC_AW)) i_dec (
        .addr_i   (bus_addr_i),
        .sel_o    (sel),
        .sub_o    (sub),
        .id_idx_o (id_idx)
    );

    hc_id_rom i_id (
        .idx_i  (id_idx),
        .byte_o (id_byte)
    );

    hc_irq_gen #(.NIRQ(HC_NIRQ), .SW(HC_STAT_W)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .mask_i   (q.mask),
        .irq_o    (irq_o)
    );

    assign rd_acc = bus_sel_i && !bus_wr_i;
    assign wr_acc = bus_sel_i && bus_wr_i;
    assign status = {q.live, q.sticky};
    assign fcnt   = ({1'b0, q.dcnt} + (HC_LEN_W+1)'(3)) >> 2;

    // read path
    always_comb begin
        bus_rdata_o = '0;
        if (rd_acc) begin
            case (sel)
                SEL_PWR:  bus_rdata_o = HC_DW'(q.pwr);
                SEL_CLK:  bus_rdata_o = HC_DW'(q.clk);
                SEL_ARG:  bus_rdata_o = q.arg;
                SEL_CMD:  bus_rdata_o = q.cmd;
                SEL_RCMD: bus_rdata_o = HC_DW'(q.rcmd);
                SEL_RESP: bus_rdata_o = q.resp[sub];
                SEL_DTMR: bus_rdata_o = q.dtmr;
                SEL_DLEN: bus_rdata_o = HC_DW'(q.dlen);
                SEL_DCTL: bus_rdata_o = HC_DW'(q.dctl);
                SEL_DCNT: bus_rdata_o = HC_DW'(q.dcnt);
                SEL_STAT: bus_rdata_o = HC_DW'(status);
                SEL_MASK: bus_rdata_o = HC_DW'(q.mask[sub[0]]);
                SEL_FCNT: bus_rdata_o = HC_DW'(fcnt);
                SEL_FIFO: bus_rdata_o = fifo_empty_i ? '0 : fifo_rdata_i;
                SEL_ID:   bus_rdata_o = HC_DW'(id_byte);
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign fifo_pop_o   = rd_acc && (sel == SEL_FIFO) && !fifo_empty_i;
    assign fifo_push_o  = wr_acc && (sel == SEL_FIFO) && (q.dcnt != '0);
    assign fifo_wdata_o = bus_wdata_i;

    // next-state
    always_comb begin
        d         = q;
        d.cmd_go  = 1'b0;
        d.data_go = 1'b0;
        d.err     = bus_sel_i && (sel == SEL_NONE);
        d.live    = live_flags_i;
        clr_bits  = '0;

        if (byte_done_i && q.dcnt != '0) d.dcnt = q.dcnt - 1'b1;

        if (resp_valid_i) begin
            d.rcmd = resp_idx_i;
            for (int k = 0; k < HC_NRESP; k++) d.resp[k] = resp_words_i[k*HC_DW +: HC_DW];
        end

        if (wr_acc) begin
            case (sel)
                SEL_PWR:  d.pwr  = bus_wdata_i[HC_NARROW_W-1:0];
                SEL_CLK:  d.clk  = bus_wdata_i[HC_NARROW_W-1:0];
                SEL_ARG:  d.arg  = bus_wdata_i;
                SEL_CMD: begin
                    d.cmd             = bus_wdata_i;
                    d.cmd[HC_GO_BIT]  = 1'b0;
                    d.cmd_go          = bus_wdata_i[HC_GO_BIT];
                end
                SEL_DTMR: d.dtmr = bus_wdata_i;
                SEL_DLEN: d.dlen = bus_wdata_i[HC_LEN_W-1:0];
                SEL_DCTL: begin
                    d.dctl = bus_wdata_i[HC_NARROW_W-1:0];
                    if (bus_wdata_i[0]) begin
                        d.dcnt    = q.dlen;
                        d.data_go = 1'b1;
                    end
                end
                SEL_CLR:  clr_bits = bus_wdata_i[HC_STICKY_W-1:0];
                SEL_MASK: d.mask[sub[0]] = bus_wdata_i[HC_STAT_W-1:0];
                default: ;
            endcase
        end

        d.sticky = (q.sticky & ~clr_bits) | evt_set_i;

        if (fifo_pop_o)                                   d.defer = 1'b1;
        else if (rd_acc && (sel == SEL_STAT || sel == SEL_FCNT)) d.defer = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_err_o    = q.err;
    assign power_o      = q.pwr;
    assign clock_o      = q.clk;
    assign cmd_word_o   = q.cmd;
    assign cmd_arg_o    = q.arg;
    assign cmd_start_o  = q.cmd_go;
    assign data_timer_o = q.dtmr;
    assign data_ctrl_o  = q.dctl;
    assign data_count_o = q.dcnt;
    assign data_start_o = q.data_go;
    assign eng_hold_o   = q.defer;

    // R10
    defer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> eng_hold_o);

    // R10
    defer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (bus_addr_i == 12'h034 || bus_addr_i == 12'h048)) |=> !eng_hold_o);

    // R6
    clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr_i == 12'h038 && bus_wdata_i[0] && !evt_set_i[0])
        |=> !bus_rdata_o[0] || bus_addr_i != 12'h034);

    // R12
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> $past(bus_sel_i));

    // R4
    count_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && bus_addr_i == 12'h02C && bus_wdata_i[0])
        |=> data_count_o <= $past(data_count_o));
endmodule

// File: tb/test_card_host_regs.sv
module test_card_host_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic [7:0]   power, clock;
    logic [31:0]  cmd_word, cmd_arg;
    logic         cmd_start;
    logic         resp_valid = 1'b0;
    logic [5:0]   resp_idx = '0;
    logic [127:0] resp_words = '0;
    logic [31:0]  data_timer;
    logic [7:0]   data_ctrl;
    logic [15:0]  data_count;
    logic         data_start;
    logic         byte_done = 1'b0;
    logic [10:0]  evt_set = '0, live_flags = '0;
    logic [31:0]  fifo_rdata = '0;
    logic         fifo_empty = 1'b1;
    logic         fifo_pop, fifo_push;
    logic [31:0]  fifo_wdata;
    logic         eng_hold;
    logic [1:0]   irq;

    int n_run = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    card_host_regs i_card_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .bus_err_o(bus_err), .power_o(power), .clock_o(clock),
        .cmd_word_o(cmd_word), .cmd_arg_o(cmd_arg), .cmd_start_o(cmd_start),
        .resp_valid_i(resp_valid), .resp_idx_i(resp_idx), .resp_words_i(resp_words),
        .data_timer_o(data_timer), .data_ctrl_o(data_ctrl), .data_count_o(data_count),
        .data_start_o(data_start), .byte_done_i(byte_done), .evt_set_i(evt_set),
        .live_flags_i(live_flags), .fifo_rdata_i(fifo_rdata), .fifo_empty_i(fifo_empty),
        .fifo_pop_o(fifo_pop), .fifo_push_o(fifo_push), .fifo_wdata_o(fifo_wdata),
        .eng_hold_o(eng_hold), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard for read data
    always @(negedge clk) begin
        #2;
        if (bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk); bus_sel = 1'b0;
    endtask

    task automatic ev(input logic [10:0] v);
        @(negedge clk); evt_set = v;
        @(negedge clk); evt_set = '0;
    endtask

    task automatic bytes(input int n);
        @(negedge clk); byte_done = 1'b1;
        repeat (n) @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic settle(); #2; endtask

    initial begin
        #(8 * 200000);
        chk("watchdog", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        settle();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 hold", 32'(eng_hold), 0);
        chk("R1 err", 32'(bus_err), 0);
        chk("R1 starts", {30'd0, cmd_start, data_start}, 0);
        rd(12'h000, 0, "R1 power");
        rd(12'h034, 0, "R1 status");
        rd(12'h03C, 0, "R1 mask0");
        rd(12'h030, 0, "R1 count");

        // R2 field widths
        wr(12'h000, 32'h1FF);      rd(12'h000, 32'hFF, "R2 power");
        wr(12'h004, 32'hABC);      rd(12'h004, 32'hBC, "R2 clock");
        wr(12'h008, 32'hDEADBEEF); rd(12'h008, 32'hDEADBEEF, "R2 arg");
        wr(12'h024, 32'h89ABCDEF); rd(12'h024, 32'h89ABCDEF, "R2 timer");
        wr(12'h028, 32'h12345);    rd(12'h028, 32'h2345, "R2 length");
        wr(12'h02C, 32'h1F0);      rd(12'h02C, 32'hF0, "R2 dctl");
        settle(); chk("R2 no data start", 32'(data_start), 0);

        // R3 command issue
        wr(12'h00C, 32'h451);
        settle(); chk("R3 start pulse", 32'(cmd_start), 1);
        @(negedge clk); settle(); chk("R3 start ends", 32'(cmd_start), 0);
        rd(12'h00C, 32'h051, "R3 go bit cleared");
        wr(12'h00C, 32'h045);
        settle(); chk("R3 no start", 32'(cmd_start), 0);

        // R4 count load and countdown
        wr(12'h028, 32'd10);
        wr(12'h02C, 32'h03);
        settle(); chk("R4 data start", 32'(data_start), 1);
        rd(12'h030, 32'd10, "R4 count load");
        rd(12'h048, 32'd3, "R4 fifo count");
        bytes(3);
        rd(12'h030, 32'd7, "R4 countdown");
        rd(12'h048, 32'd2, "R4 fifo count 7");

        // R11 fifo write with count nonzero
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h09C; bus_wdata = 32'h13579BDF;
        settle(); chk("R11 push", 32'(fifo_push), 1); chk("R11 push data", fifo_wdata, 32'h13579BDF);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;

        // R9 / R10 fifo read and hold
        fifo_empty = 1'b0; fifo_rdata = 32'hCAFE0001;
        @(negedge clk); bus_sel = 1'b1; bus_addr = 12'h0B4;
        exp_q.push_back(32'hCAFE0001); tag_q.push_back("R9 fifo data");
        settle(); chk("R9 pop", 32'(fifo_pop), 1);
        @(negedge clk); bus_sel = 1'b0;
        settle(); chk("R10 hold set", 32'(eng_hold), 1);
        rd(12'h034, 0, "R10 status during hold");
        settle(); chk("R10 status releases", 32'(eng_hold), 0);
        rd(12'h080, 32'hCAFE0001, "R9 alias 0x80");
        settle(); chk("R10 hold again", 32'(eng_hold), 1);
        rd(12'h048, 32'd2, "R10 fifo count read");
        settle(); chk("R10 count releases", 32'(eng_hold), 0);
        fifo_empty = 1'b1;
        @(negedge clk); bus_sel = 1'b1; bus_addr = 12'h0A0;
        exp_q.push_back(0); tag_q.push_back("R9 empty reads 0");
        settle(); chk("R9 no pop", 32'(fifo_pop), 0);
        @(negedge clk); bus_sel = 1'b0;
        settle(); chk("R9 no hold", 32'(eng_hold), 0);

        // R4 stop at zero, R11 ignored write
        bytes(9);
        rd(12'h030, 0, "R4 stops at zero");
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h084; bus_wdata = 32'h1;
        settle(); chk("R11 ignored", 32'(fifo_push), 0);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;

        // R5 response capture
        @(negedge clk); resp_valid = 1'b1; resp_idx = 6'h11;
        resp_words = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
        @(negedge clk); resp_valid = 1'b0;
        rd(12'h010, 32'h11, "R5 index");
        rd(12'h014, 32'h11111111, "R5 word0");
        rd(12'h018, 32'h22222222, "R5 word1");
        rd(12'h01C, 32'h33333333, "R5 word2");
        rd(12'h020, 32'h44444444, "R5 word3");

        // R6 status
        live_flags = 11'h5A5;
        ev(11'h009);
        rd(12'h034, 32'h002D2809, "R6 sticky+live");
        wr(12'h038, 32'hFFFF_FFFF);
        rd(12'h034, 32'h002D2800, "R6 clear low only");
        @(negedge clk); evt_set = 11'h002; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h2;
        @(negedge clk); evt_set = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(12'h034, 32'h002D2802, "R6 set beats clear");
        wr(12'h038, 32'h2);

        // R7 interrupts
        wr(12'h03C, 32'h8);
        ev(11'h008);
        settle(); chk("R7 irq0 lag", 32'(irq[0]), 0);
        @(negedge clk); settle(); chk("R7 irq0 high", 32'(irq[0]), 1);
        wr(12'h038, 32'h8);
        settle(); chk("R7 irq0 lag low", 32'(irq[0]), 1);
        @(negedge clk); settle(); chk("R7 irq0 low", 32'(irq[0]), 0);
        wr(12'h040, 32'h800);
        settle(); chk("R7 irq1 lag", 32'(irq[1]), 0);
        @(negedge clk); settle(); chk("R7 irq1 high", 32'(irq[1]), 1);
        rd(12'h040, 32'h800, "R7 mask1 readback");

        // R8 identification
        rd(12'hFE0, 32'h81, "R8 id0"); rd(12'hFE4, 32'h11, "R8 id1");
        rd(12'hFE8, 32'h04, "R8 id2"); rd(12'hFEC, 32'h00, "R8 id3");
        rd(12'hFF0, 32'h0D, "R8 id4"); rd(12'hFF4, 32'hF0, "R8 id5");
        rd(12'hFF8, 32'h05, "R8 id6"); rd(12'hFFC, 32'hB1, "R8 id7");

        // R12 unmapped
        rd(12'h044, 0, "R12 read zero");
        settle(); chk("R12 err pulse", 32'(bus_err), 1);
        @(negedge clk); settle(); chk("R12 err one cycle", 32'(bus_err), 0);
        wr(12'h001, 32'h77);
        settle(); chk("R12 misaligned err", 32'(bus_err), 1);
        rd(12'h000, 32'hFF, "R12 power unchanged");

        @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule